// File: doc/BRIEF.md
# Ripple-Carry Integer ALU with Trapping Overflow

This block is the integer arithmetic and logic unit of a small load/store core. It forms a single-cycle result from two 32-bit operands and a 4-bit operation code. The datapath is a chain of identical one-bit slices linked through their carries. Each slice computes a full-adder sum and carry and holds a per-bit multiplexer. The multiplexer selects between AND, OR, the sum and a "less" input. Subtraction reuses the same chain: the B operand is inverted and a carry of one is seeded into bit 0.

Signed and unsigned comparison share the subtract path. The signed result is the sign of A−B corrected by the signed-overflow bit. The unsigned result is the inverted final carry. Signed overflow is derived from the operand and result signs, using the effective (possibly inverted) B. It raises an exception request only for the trapping add and subtract. The wrap-around forms never trap. The result is always presented, so the core can discard it when a trap is taken.

A companion widener turns a 16-bit immediate, or the low byte of a loaded value, into a 32-bit operand. It either replicates the top bit of the field or fills the upper bits with zeros. All outputs are purely combinational.

Top module: `rc_alu`

## Requirements
- R1: Code 0 gives the bitwise AND of A and B and code 1 the bitwise OR; for both, carry_out is 0 and trap is 0.
- R2: Codes 2 (trapping add) and 3 (wrapping add) give (A+B) mod 2^32, and carry_out equals bit 32 of the unsigned sum.
- R3: Codes 4 (trapping subtract) and 5 (wrapping subtract) give (A−B) mod 2^32, and carry_out is 1 exactly when A ≥ B as unsigned numbers.
- R4: With code 2, trap is 1 exactly when the signed sum of A and B does not fit in 32-bit two's complement.
- R5: With code 4, trap is 1 exactly when the signed difference A−B does not fit in 32-bit two's complement.
- R6: Every code other than 2 and 4 leaves trap at 0, whatever the operands are; this includes the wrapping add and subtract.
- R7: Code 6 gives 1 in bit 0 when A < B as signed numbers and 0 otherwise, with bits 31:1 cleared; carry_out is the subtract carry (as in R3).
- R8: Code 7 gives 1 in bit 0 when A < B as unsigned numbers and 0 otherwise, with bits 31:1 cleared; carry_out is the subtract carry (as in R3).
- R9: zero is 1 exactly when all 32 result bits are 0, for every code.
- R10: Codes 8 to 15 give a result of 0 with carry_out 0 and trap 0, so zero is 1.
- R11: With ext_byte=0, ext_out holds ext_in[15:0] in bits 15:0. Bits 31:16 are copies of ext_in[15] when ext_sign=1, and zeros when ext_sign=0.
- R12: With ext_byte=1, ext_out holds ext_in[7:0] in bits 7:0. Bits 31:8 are copies of ext_in[7] when ext_sign=1, and zeros when ext_sign=0; ext_in[15:8] is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| op | input | 4 | Operation code (0 AND, 1 OR, 2 add-trap, 3 add-wrap, 4 sub-trap, 5 sub-wrap, 6 signed less, 7 unsigned less) |
| result | output | 32 | Operation result |
| carry_out | output | 1 | Final carry of the chain for arithmetic and compare codes, else 0 |
| zero | output | 1 | All result bits are 0 |
| trap | output | 1 | Overflow exception request of the trapping add or subtract |
| ext_in | input | 16 | Immediate or loaded value to widen |
| ext_byte | input | 1 | 1 widens bits 7:0, 0 widens bits 15:0 |
| ext_sign | input | 1 | 1 replicates the top field bit, 0 fills with zeros |
| ext_out | output | 32 | Widened operand |

## Verification
The assertions take for granted that op, opa, opb and the widener inputs are settled two-state values. They are sampled only once the combinational chain has resolved after a change. The bench therefore drives every input on the falling clock edge and compares one time unit later. The operands include sign-boundary values (0x7FFFFFFF, 0x80000000, 0xFFFFFFFF, 0, 1) and random patterns across all sixteen codes. This places the overflow and compare corners inside the checked window.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_AND  = 4'd0;
    localparam logic [OP_W-1:0] OP_OR   = 4'd1;
    localparam logic [OP_W-1:0] OP_ADD  = 4'd2;
    localparam logic [OP_W-1:0] OP_ADDU = 4'd3;
    localparam logic [OP_W-1:0] OP_SUB  = 4'd4;
    localparam logic [OP_W-1:0] OP_SUBU = 4'd5;
    localparam logic [OP_W-1:0] OP_SLT  = 4'd6;
    localparam logic [OP_W-1:0] OP_SLTU = 4'd7;

    // per-bit output selector inside each slice
    typedef enum logic [1:0] {
        SEL_AND  = 2'd0,
        SEL_OR   = 2'd1,
        SEL_SUM  = 2'd2,
        SEL_LESS = 2'd3
    } slice_sel_e;

    typedef enum logic [1:0] {
        CMP_NONE     = 2'd0,
        CMP_SIGNED   = 2'd1,
        CMP_UNSIGNED = 2'd2
    } cmp_kind_e;

    typedef struct packed {
        logic       b_invert;    // invert B before the adder
        logic       carry_seed;  // carry into bit 0
        slice_sel_e sel;         // slice output choice
        logic       arith;       // carry_out is meaningful
        logic       trap_en;     // overflow may raise trap
        cmp_kind_e  cmp;         // which less bit feeds bit 0
        logic       kill;        // unused code: force zero result
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_op(input logic [OP_W-1:0] code);
        alu_ctrl_t c;
        c.b_invert   = 1'b0;
        c.carry_seed = 1'b0;
        c.sel        = SEL_AND;
        c.arith      = 1'b0;
        c.trap_en    = 1'b0;
        c.cmp        = CMP_NONE;
        c.kill       = 1'b0;
        case (code)
            OP_AND:  c.sel = SEL_AND;
            OP_OR:   c.sel = SEL_OR;
            OP_ADD: begin
                c.sel     = SEL_SUM;
                c.arith   = 1'b1;
                c.trap_en = 1'b1;
            end
            OP_ADDU: begin
                c.sel   = SEL_SUM;
                c.arith = 1'b1;
            end
            OP_SUB: begin
                c.sel        = SEL_SUM;
                c.b_invert   = 1'b1;
                c.carry_seed = 1'b1;
                c.arith      = 1'b1;
                c.trap_en    = 1'b1;
            end
            OP_SUBU: begin
                c.sel        = SEL_SUM;
                c.b_invert   = 1'b1;
                c.carry_seed = 1'b1;
                c.arith      = 1'b1;
            end
            OP_SLT: begin
                c.sel        = SEL_LESS;
                c.b_invert   = 1'b1;
                c.carry_seed = 1'b1;
                c.arith      = 1'b1;
                c.cmp        = CMP_SIGNED;
            end
            OP_SLTU: begin
                c.sel        = SEL_LESS;
                c.b_invert   = 1'b1;
                c.carry_seed = 1'b1;
                c.arith      = 1'b1;
                c.cmp        = CMP_UNSIGNED;
            end
            default: c.kill = 1'b1;
        endcase
        return c;
    endfunction

    // signed overflow from the sign bits of A, effective B and the sum
    function automatic logic sign_overflow(input logic a_msb,
                                           input logic b_eff_msb,
                                           input logic sum_msb);
        return (a_msb == b_eff_msb) && (sum_msb != a_msb);
    endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic       b_invert,
    input  logic       carry_in,
    input  logic       less_in,
    input  slice_sel_e sel,
    output logic       res,
    output logic       sum,
    output logic       b_eff,
    output logic       carry_out
);

    always_comb begin
        b_eff     = b ^ b_invert;
        sum       = a ^ b_eff ^ carry_in;
        carry_out = (a & b_eff) | (a & carry_in) | (b_eff & carry_in);
        case (sel)
            SEL_AND:  res = a & b_eff;
            SEL_OR:   res = a | b_eff;
            SEL_SUM:  res = sum;
            default:  res = less_in;
        endcase
    end

endmodule

// File: rtl/alu_ripple.sv
module alu_ripple
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         b_invert,
    input  logic         carry_seed,
    input  slice_sel_e   sel,
    input  logic         set_bit,
    output logic [W-1:0] res,
    output logic         sum_msb,
    output logic         b_eff_msb,
    output logic         carry_final
);

    logic [W:0]   carry;
    logic [W-1:0] sum_v;
    logic [W-1:0] beff_v;

    assign carry[0] = carry_seed;

    for (genvar i = 0; i < W; i++) begin : g_slice
        logic less_i;
        if (i == 0) begin : g_lsb
            assign less_i = set_bit;
        end else begin : g_upper
            assign less_i = 1'b0;
        end

        alu_bit_slice u_slice (
            .a        (a[i]),
            .b        (b[i]),
            .b_invert (b_invert),
            .carry_in (carry[i]),
            .less_in  (less_i),
            .sel      (sel),
            .res      (res[i]),
            .sum      (sum_v[i]),
            .b_eff    (beff_v[i]),
            .carry_out(carry[i+1])
        );
    end

    assign sum_msb     = sum_v[W-1];
    assign b_eff_msb   = beff_v[W-1];
    assign carry_final = carry[W];

endmodule

// File: rtl/alu_status.sv
module alu_status
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_ctrl_t    ctrl,
    input  logic         a_msb,
    input  logic         b_eff_msb,
    input  logic         sum_msb,
    input  logic         chain_carry,
    input  logic [W-1:0] chain_res,
    output logic         set_bit,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         zero,
    output logic         trap
);

    logic ovf;

    always_comb begin
        ovf = sign_overflow(a_msb, b_eff_msb, sum_msb);
        case (ctrl.cmp)
            CMP_SIGNED:   set_bit = sum_msb ^ ovf;
            CMP_UNSIGNED: set_bit = ~chain_carry;
            default:      set_bit = 1'b0;
        endcase
        result    = ctrl.kill ? '0 : chain_res;
        carry_out = ctrl.arith & chain_carry;
        trap      = ctrl.trap_en & ovf;
        zero      = ~|result;
    end

endmodule

// File: rtl/imm_extend.sv
module imm_extend #(
    parameter int OUT_W  = 32,
    parameter int HALF_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [HALF_W-1:0] val_in,
    input  logic              byte_mode,
    input  logic              sign_mode,
    output logic [OUT_W-1:0]  val_out
);

    localparam int HALF_PAD = OUT_W - HALF_W;
    localparam int BYTE_PAD = OUT_W - BYTE_W;

    logic             half_fill;
    logic             byte_fill;
    logic [OUT_W-1:0] half_wide;
    logic [OUT_W-1:0] byte_wide;

    always_comb begin
        half_fill = sign_mode & val_in[HALF_W-1];
        byte_fill = sign_mode & val_in[BYTE_W-1];
        half_wide = {{HALF_PAD{half_fill}}, val_in};
        byte_wide = {{BYTE_PAD{byte_fill}}, val_in[BYTE_W-1:0]};
        val_out   = byte_mode ? byte_wide : half_wide;
    end

endmodule

// File: rtl/rc_alu.sv
module rc_alu
    import alu_pkg::*;
#(
    parameter int W      = 32,
    parameter int IMM_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic [OP_W-1:0]  op,
    output logic [W-1:0]     result,
    output logic             carry_out,
    output logic             zero,
    output logic             trap,
    input  logic [IMM_W-1:0] ext_in,
    input  logic             ext_byte,
    input  logic             ext_sign,
    output logic [W-1:0]     ext_out
);

    alu_ctrl_t    ctrl;
    logic [W-1:0] chain_res;
    logic         sum_msb;
    logic         b_eff_msb;
    logic         chain_carry;
    logic         set_bit;

    assign ctrl = decode_op(op);

    alu_ripple #(.W(W)) u_chain (
        .a          (opa),
        .b          (opb),
        .b_invert   (ctrl.b_invert),
        .carry_seed (ctrl.carry_seed),
        .sel        (ctrl.sel),
        .set_bit    (set_bit),
        .res        (chain_res),
        .sum_msb    (sum_msb),
        .b_eff_msb  (b_eff_msb),
        .carry_final(chain_carry)
    );

    alu_status #(.W(W)) u_status (
        .ctrl       (ctrl),
        .a_msb      (opa[W-1]),
        .b_eff_msb  (b_eff_msb),
        .sum_msb    (sum_msb),
        .chain_carry(chain_carry),
        .chain_res  (chain_res),
        .set_bit    (set_bit),
        .result     (result),
        .carry_out  (carry_out),
        .zero       (zero),
        .trap       (trap)
    );

    imm_extend #(.OUT_W(W), .HALF_W(IMM_W), .BYTE_W(BYTE_W)) u_ext (
        .val_in   (ext_in),
        .byte_mode(ext_byte),
        .sign_mode(ext_sign),
        .val_out  (ext_out)
    );

endmodule

// File: rtl/rc_alu_checker.sv
module rc_alu_checker
    import alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input logic [W-1:0]     opa,
    input logic [W-1:0]     opb,
    input logic [OP_W-1:0]  op,
    input logic [W-1:0]     result,
    input logic             carry_out,
    input logic             trap,
    input logic [IMM_W-1:0] ext_in,
    input logic             ext_byte,
    input logic             ext_sign,
    input logic [W-1:0]     ext_out
);

    localparam int PAD = W - IMM_W;

    always_comb begin
        // R4: trapping add flags same-sign operands giving an opposite-sign result
        if (op == OP_ADD)
            a_r4_add_trap: assert (trap == ((opa[W-1] == opb[W-1]) && (result[W-1] != opa[W-1])));
        // R5: trapping subtract flags different-sign operands whose result takes B's sign
        if (op == OP_SUB)
            a_r5_sub_trap: assert (trap == ((opa[W-1] != opb[W-1]) && (result[W-1] != opa[W-1])));
        // R6: only the two trapping codes may raise trap
        if (op != OP_ADD && op != OP_SUB)
            a_r6_no_trap: assert (!trap);
        // R7 and R8: compare results occupy bit 0 only
        if (op == OP_SLT || op == OP_SLTU)
            a_r7_cmp_upper_clear: assert (result[W-1:1] == '0);
        // R10: codes above 7 produce nothing
        if (op > OP_SLTU)
            a_r10_unused_quiet: assert (result == '0 && !carry_out && !trap);
        // R11: sign-widened halfword has all upper bits equal to the field's top bit
        if (!ext_byte && ext_sign)
            a_r11_half_sign: assert (ext_out[W-1:IMM_W] == {PAD{ext_in[IMM_W-1]}});
    end

endmodule

bind rc_alu rc_alu_checker #(.W(W), .IMM_W(IMM_W)) u_checker (
    .opa      (opa),
    .opb      (opb),
    .op       (op),
    .result   (result),
    .carry_out(carry_out),
    .trap     (trap),
    .ext_in   (ext_in),
    .ext_byte (ext_byte),
    .ext_sign (ext_sign),
    .ext_out  (ext_out)
);

// File: tb/test_rc_alu.sv
module test_rc_alu;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [3:0]  op  = '0;
    logic [15:0] ext_in = '0;
    logic        ext_byte = 1'b0;
    logic        ext_sign = 1'b0;
    logic [31:0] result;
    logic        carry_out;
    logic        zero;
    logic        trap;
    logic [31:0] ext_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rc_alu i_rc_alu (
        .opa      (opa),
        .opb      (opb),
        .op       (op),
        .result   (result),
        .carry_out(carry_out),
        .zero     (zero),
        .trap     (trap),
        .ext_in   (ext_in),
        .ext_byte (ext_byte),
        .ext_sign (ext_sign),
        .ext_out  (ext_out)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: op=%0d a=%h b=%h actual=%h expected=%h",
                     tag, what, op, opa, opb, act, exp);
        end
    endtask

    // behavioural reference: integer arithmetic, no slice structure
    task automatic apply(input logic [31:0] a, input logic [31:0] b, input int code,
                         input logic [15:0] xin, input bit xbyte, input bit xsign);
        longint      sa, sb, wide;
        logic [32:0] full;
        logic [31:0] e_res;
        logic        e_carry, e_trap;
        logic [31:0] e_ext;
        string       tag, ttag;
        @(negedge clk);
        opa = a; opb = b; op = 4'(code);
        ext_in = xin; ext_byte = xbyte; ext_sign = xsign;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        e_res = '0; e_carry = 1'b0; e_trap = 1'b0;
        full = 33'({1'b0, a}) + 33'({1'b0, b});
        if (code >= 4 && code <= 7) full = 33'({1'b0, a}) - 33'({1'b0, b}) + 33'h1_0000_0000;
        case (code)
            0: begin e_res = a & b; tag = "R1"; end
            1: begin e_res = a | b; tag = "R1"; end
            2, 3: begin e_res = full[31:0]; e_carry = full[32]; tag = "R2"; end
            4, 5: begin e_res = full[31:0]; e_carry = (a >= b); tag = "R3"; end
            6: begin e_res = {31'd0, (sa < sb)}; e_carry = (a >= b); tag = "R7"; end
            7: begin e_res = {31'd0, (a < b)}; e_carry = (a >= b); tag = "R8"; end
            default: tag = "R10";
        endcase
        wide = (code == 2) ? sa + sb : sa - sb;
        if (code == 2 || code == 4)
            e_trap = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
        ttag = (code == 2) ? "R4" : (code == 4) ? "R5" : "R6";
        if (xbyte) e_ext = xsign ? {{24{xin[7]}}, xin[7:0]} : {24'd0, xin[7:0]};
        else       e_ext = xsign ? {{16{xin[15]}}, xin} : {16'd0, xin};
        #1;
        check(result === e_res, tag, "result", result, e_res);
        check(carry_out === e_carry, tag, "carry", 32'(carry_out), 32'(e_carry));
        check(trap === e_trap, ttag, "trap", 32'(trap), 32'(e_trap));
        check(zero === (e_res == 0), "R9", "zero", 32'(zero), 32'(e_res == 0));
        check(ext_out === e_ext, xbyte ? "R12" : "R11", "ext", ext_out, e_ext);
    endtask

    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        n_fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        // initial state with all inputs zero: R9 zero asserted, nothing else
        #1;
        check(result === 32'd0 && zero === 1'b1 && trap === 1'b0, "R9", "idle",
              {result[31:1], zero}, 32'd1);

        // R1 logic
        apply(32'hF0F0_1234, 32'h0FF0_FF00, 0, 16'h0000, 0, 0);
        apply(32'hF0F0_1234, 32'h0FF0_FF00, 1, 16'h0000, 0, 0);
        // R2 / R4 add corners
        apply(32'h7FFF_FFFF, 32'h0000_0001, 2, 16'h0080, 1, 1);
        apply(32'h7FFF_FFFF, 32'h0000_0001, 3, 16'h0080, 1, 0);
        apply(32'h8000_0000, 32'h8000_0000, 2, 16'h8001, 0, 1);
        apply(32'hFFFF_FFFF, 32'h0000_0001, 2, 16'h8001, 0, 0);
        apply(32'h8000_0000, 32'h8000_0000, 3, 16'hAB7F, 1, 1);
        // R3 / R5 subtract corners
        apply(32'h8000_0000, 32'h0000_0001, 4, 16'hFF12, 1, 1);
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4, 16'h0000, 0, 0);
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 5, 16'h0000, 0, 0);
        apply(32'h0000_0005, 32'h0000_0005, 4, 16'h0000, 0, 0);
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFE, 4, 16'h0000, 0, 0);
        // R7 / R8 compare corners
        apply(32'hFFFF_FFFF, 32'h0000_0001, 6, 16'h0000, 0, 0);
        apply(32'hFFFF_FFFF, 32'h0000_0001, 7, 16'h0000, 0, 0);
        apply(32'h8000_0000, 32'h0000_0001, 6, 16'h0000, 0, 0);
        apply(32'h7FFF_FFFF, 32'h8000_0000, 6, 16'h0000, 0, 0);
        apply(32'h0000_0003, 32'h0000_0003, 7, 16'h0000, 0, 0);
        // R10 unused codes with overflowing operands
        apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, 9, 16'h0000, 0, 0);
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 15, 16'h0000, 0, 0);

        // random sweep across every code, sign-boundary operands mixed in
        for (int i = 0; i < 6000; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            if (i % 7 == 0) ra = {ra[31], 31'h7FFF_FFFF} ^ {1'b0, {31{ra[0]}}};
            if (i % 11 == 0) rb = ra;
            apply(ra, rb, i % 16, 16'($urandom()), 1'($urandom()), 1'($urandom()));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule